// File: doc/BRIEF.md
# PC Keyboard Controller Command Processor

This block is the host-side register engine of a PC-style keyboard controller. The host writes bytes to one of two ports, chosen by a select input: the command port or the data port. A write to the command port is decoded at once. It either takes an immediate action (a reply byte, a change to a mode bit, a change to the A20 gate, or a system reset pulse) or it arms an operand command. An armed operand command consumes the next data-port byte. A data byte that arrives with nothing armed is passed on to the keyboard-side logic.

The block holds three registers: the mode byte, the status byte and the output port byte. It drives the A20 gate level, a one-cycle system reset request and a scan-code translation enable. Reply bytes leave as one-cycle strobes toward an external response queue, tagged keyboard-side or auxiliary-side. Bytes meant for the mouse leave through their own strobe. Every output is registered, so the effect of a host write shows on the cycle after the clock edge that takes it.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After a synchronous reset the registers hold these values: mode 0x03, status 0x18 and output port 0xCF. A20 is high and all strobes are low.
- R2: Status bit 3 is 1 after a command-port write and 0 after a data-port write. Command 0xAA sets status bit 2 and replies 0x55.
- R3: Command 0x20 replies with the current mode byte and 0xD0 with the current output port byte. Commands 0xA9 and 0xAB reply 0x00 and 0xC0 replies 0x80. All of these are keyboard-side replies (rsp_aux = 0).
- R4: Commands 0xAD and 0xAE set and clear mode bit 4. Commands 0xA7 and 0xA8 set and clear mode bit 5.
- R5: After command 0x60 the next data byte replaces the mode byte. xlate_en always equals mode bit 6.
- R6: After command 0xD1 the next data byte replaces the output port. A20 follows bit 1 of that byte, and a reset request is pulsed when bit 0 of that byte is 0.
- R7: After command 0xD2 or 0xD3 the next data byte is emitted as a reply, keyboard-side for 0xD2 and auxiliary-side for 0xD3. After command 0xD4 the next data byte is emitted on the mouse forward strobe.
- R8: An armed operand command consumes exactly one data byte. A data byte with nothing armed goes out on the keyboard forward strobe.
- R9: Command 0xDF raises A20 and sets output port bit 1. Command 0xDD lowers A20 and clears that bit.
- R10: Any command 0xF0 to 0xFF with bit 0 equal to 0 pulses the reset request for one cycle. With bit 0 equal to 1 the command has no effect.
- R11: An unlisted command pulses bad_cmd for one cycle and changes no register other than status bit 3.
- R12: A command-port write that arrives while an operand is armed discards that armed operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_cmd_sel | input | 1 | 1 selects the command port, 0 the data port |
| host_wdata | input | 8 | Host write byte |
| status_byte | output | 8 | Status register |
| mode_byte | output | 8 | Mode register |
| port_byte | output | 8 | Output port register |
| xlate_en | output | 1 | Scan-code translation enable |
| a20_gate | output | 1 | A20 gate level |
| sys_rst_req | output | 1 | One-cycle system reset request |
| rsp_valid | output | 1 | Reply byte strobe |
| rsp_aux | output | 1 | Reply belongs to the auxiliary side |
| rsp_data | output | 8 | Reply byte |
| kbd_fwd_valid | output | 1 | Keyboard forward strobe |
| kbd_fwd_data | output | 8 | Byte for the keyboard |
| aux_fwd_valid | output | 1 | Mouse forward strobe |
| aux_fwd_data | output | 8 | Byte for the mouse |
| bad_cmd | output | 1 | Unknown command strobe |

## Verification
The bench goes after several corner cases.

- Operand hand-off. A design that keeps an operand armed after one byte would send the second byte into the mode or port register instead of forwarding it to the keyboard.
- Pulse commands. A design that decodes only 0xFE, or that ignores bit 0, would miss reset pulses for 0xF0 to 0xFC or would reset on 0xFF.
- A command that arrives while an operand is armed. Mishandling this would send a later data byte to the wrong target.
- Output port writes with bit 0 clear. Missing the reset pulse shows up here, as does an A20 gate that does not follow bit 1.
- Unknown commands. A design that touches the mode or output port registers on an unknown command is caught here.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int BW = 8;
    typedef logic [BW-1:0] byte_t;

    localparam byte_t MODE_RST = 8'h03;
    localparam byte_t STAT_RST = 8'h18;
    localparam byte_t PORT_RST = 8'hCF;

    localparam int MODE_KDIS    = 4;
    localparam int MODE_ADIS    = 5;
    localparam int MODE_XLAT    = 6;
    localparam int STAT_PASS    = 2;
    localparam int STAT_LASTCMD = 3;
    localparam int PORT_NRST    = 0;
    localparam int PORT_A20     = 1;

    localparam byte_t PASS_REPLY = 8'h55;
    localparam byte_t INPORT_VAL = 8'h80;

    typedef enum logic [2:0] {
        OP_NONE, OP_MODE, OP_PORT, OP_KINJ, OP_AINJ, OP_MOUSE
    } oper_e;

    typedef enum logic [1:0] {
        RS_NONE, RS_CONST, RS_MODE, RS_PORT
    } rsrc_e;

    typedef struct packed {
        rsrc_e rsrc;
        byte_t rconst;
        oper_e pend;
        logic  kdis_set;
        logic  kdis_clr;
        logic  adis_set;
        logic  adis_clr;
        logic  a20_set;
        logic  a20_clr;
        logic  pass;
        logic  rst_req;
        logic  bad;
    } cmd_act_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  byte_t    cmd,
    output cmd_act_t act
);
    always_comb begin
        act        = '0;
        act.rsrc   = RS_NONE;
        act.pend   = OP_NONE;
        casez (cmd)
            8'h20: act.rsrc = RS_MODE;
            8'hD0: act.rsrc = RS_PORT;
            8'hA9, 8'hAB: begin
                act.rsrc   = RS_CONST;
                act.rconst = 8'h00;
            end
            8'hC0: begin
                act.rsrc   = RS_CONST;
                act.rconst = INPORT_VAL;
            end
            8'hAA: begin
                act.rsrc   = RS_CONST;
                act.rconst = PASS_REPLY;
                act.pass   = 1'b1;
            end
            8'h60: act.pend = OP_MODE;
            8'hD1: act.pend = OP_PORT;
            8'hD2: act.pend = OP_KINJ;
            8'hD3: act.pend = OP_AINJ;
            8'hD4: act.pend = OP_MOUSE;
            8'hA7: act.adis_set = 1'b1;
            8'hA8: act.adis_clr = 1'b1;
            8'hAD: act.kdis_set = 1'b1;
            8'hAE: act.kdis_clr = 1'b1;
            8'hDF: act.a20_set  = 1'b1;
            8'hDD: act.a20_clr  = 1'b1;
            8'hF?: act.rst_req  = ~cmd[0];
            default: act.bad    = 1'b1;
        endcase
    end
endmodule

// File: rtl/kbc_ctrl_regs.sv
module kbc_ctrl_regs
    import kbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  logic     sel_cmd,
    input  byte_t    wdata,
    input  cmd_act_t act,
    output byte_t    mode,
    output byte_t    status,
    output byte_t    port,
    output logic     a20,
    output oper_e    pend
);
    logic cmd_w, dat_w;
    assign cmd_w = wr & sel_cmd;
    assign dat_w = wr & ~sel_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MODE_RST;
            status <= STAT_RST;
            port   <= PORT_RST;
            a20    <= PORT_RST[PORT_A20];
            pend   <= OP_NONE;
        end else begin
            if (wr) status[STAT_LASTCMD] <= sel_cmd;
            if (cmd_w) begin
                pend <= act.pend;
                if (act.pass)     status[STAT_PASS] <= 1'b1;
                if (act.kdis_set) mode[MODE_KDIS]   <= 1'b1;
                if (act.kdis_clr) mode[MODE_KDIS]   <= 1'b0;
                if (act.adis_set) mode[MODE_ADIS]   <= 1'b1;
                if (act.adis_clr) mode[MODE_ADIS]   <= 1'b0;
                if (act.a20_set) begin
                    port[PORT_A20] <= 1'b1;
                    a20            <= 1'b1;
                end
                if (act.a20_clr) begin
                    port[PORT_A20] <= 1'b0;
                    a20            <= 1'b0;
                end
            end
            if (dat_w) begin
                pend <= OP_NONE;
                case (pend)
                    OP_MODE: mode <= wdata;
                    OP_PORT: begin
                        port <= wdata;
                        a20  <= wdata[PORT_A20];
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r2_last_port: assert property (@(posedge clk) disable iff (rst)
        wr |=> status[STAT_LASTCMD] == $past(sel_cmd));
    a_r6_a20_follows: assert property (@(posedge clk) disable iff (rst)
        (dat_w && pend == OP_PORT) |=> a20 == $past(wdata[PORT_A20]));
    a_r8_one_byte: assert property (@(posedge clk) disable iff (rst)
        dat_w |=> pend == OP_NONE);
    a_r4_mode_quiet: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(mode));
endmodule

// File: rtl/kbc_out_stage.sv
module kbc_out_stage
    import kbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  logic     sel_cmd,
    input  byte_t    wdata,
    input  cmd_act_t act,
    input  oper_e    pend,
    input  byte_t    mode,
    input  byte_t    port,
    output logic     sys_rst_req,
    output logic     rsp_valid,
    output logic     rsp_aux,
    output byte_t    rsp_data,
    output logic     kbd_fwd_valid,
    output byte_t    kbd_fwd_data,
    output logic     aux_fwd_valid,
    output byte_t    aux_fwd_data,
    output logic     bad_cmd
);
    byte_t rsel;
    always_comb begin
        case (act.rsrc)
            RS_MODE: rsel = mode;
            RS_PORT: rsel = port;
            default: rsel = act.rconst;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_rst_req   <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_aux       <= 1'b0;
            rsp_data      <= '0;
            kbd_fwd_valid <= 1'b0;
            kbd_fwd_data  <= '0;
            aux_fwd_valid <= 1'b0;
            aux_fwd_data  <= '0;
            bad_cmd       <= 1'b0;
        end else begin
            sys_rst_req   <= 1'b0;
            rsp_valid     <= 1'b0;
            kbd_fwd_valid <= 1'b0;
            aux_fwd_valid <= 1'b0;
            bad_cmd       <= 1'b0;
            if (wr && sel_cmd) begin
                sys_rst_req <= act.rst_req;
                bad_cmd     <= act.bad;
                if (act.rsrc != RS_NONE) begin
                    rsp_valid <= 1'b1;
                    rsp_aux   <= 1'b0;
                    rsp_data  <= rsel;
                end
            end else if (wr) begin
                case (pend)
                    OP_NONE: begin
                        kbd_fwd_valid <= 1'b1;
                        kbd_fwd_data  <= wdata;
                    end
                    OP_PORT: sys_rst_req <= ~wdata[PORT_NRST];
                    OP_KINJ, OP_AINJ: begin
                        rsp_valid <= 1'b1;
                        rsp_aux   <= (pend == OP_AINJ);
                        rsp_data  <= wdata;
                    end
                    OP_MOUSE: begin
                        aux_fwd_valid <= 1'b1;
                        aux_fwd_data  <= wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_valid, kbd_fwd_valid, aux_fwd_valid, bad_cmd}));
    a_r10_rst_after_write: assert property (@(posedge clk) disable iff (rst)
        sys_rst_req |-> $past(wr));
    a_r8_fwd_after_data: assert property (@(posedge clk) disable iff (rst)
        kbd_fwd_valid |-> $past(wr && !sel_cmd));
endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
    import kbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_cmd_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] status_byte,
    output logic [7:0] mode_byte,
    output logic [7:0] port_byte,
    output logic       xlate_en,
    output logic       a20_gate,
    output logic       sys_rst_req,
    output logic       rsp_valid,
    output logic       rsp_aux,
    output logic [7:0] rsp_data,
    output logic       kbd_fwd_valid,
    output logic [7:0] kbd_fwd_data,
    output logic       aux_fwd_valid,
    output logic [7:0] aux_fwd_data,
    output logic       bad_cmd
);
    cmd_act_t act;
    oper_e    pend;

    kbc_cmd_decode u_dec (
        .cmd (host_wdata),
        .act (act)
    );

    kbc_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (host_wr),
        .sel_cmd (host_cmd_sel),
        .wdata   (host_wdata),
        .act     (act),
        .mode    (mode_byte),
        .status  (status_byte),
        .port    (port_byte),
        .a20     (a20_gate),
        .pend    (pend)
    );

    kbc_out_stage u_out (
        .clk           (clk),
        .rst           (rst),
        .wr            (host_wr),
        .sel_cmd       (host_cmd_sel),
        .wdata         (host_wdata),
        .act           (act),
        .pend          (pend),
        .mode          (mode_byte),
        .port          (port_byte),
        .sys_rst_req   (sys_rst_req),
        .rsp_valid     (rsp_valid),
        .rsp_aux       (rsp_aux),
        .rsp_data      (rsp_data),
        .kbd_fwd_valid (kbd_fwd_valid),
        .kbd_fwd_data  (kbd_fwd_data),
        .aux_fwd_valid (aux_fwd_valid),
        .aux_fwd_data  (aux_fwd_data),
        .bad_cmd       (bad_cmd)
    );

    assign xlate_en = mode_byte[MODE_XLAT];

    a_r5_xlate_tracks: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_cmd_sel && pend == OP_MODE) |=> xlate_en == $past(host_wdata[6]));
endmodule

// File: tb/kbc_cmd_proc_bench.sv
`timescale 1ns/1ps
module kbc_cmd_proc_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_cmd_sel = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] status_byte, mode_byte, port_byte, rsp_data, kbd_fwd_data, aux_fwd_data;
    logic       xlate_en, a20_gate, sys_rst_req, rsp_valid, rsp_aux;
    logic       kbd_fwd_valid, aux_fwd_valid, bad_cmd;

    int checks = 0;
    int failures = 0;

    // model state; pending: 0 none, 1 mode, 2 port, 3 kbd reply, 4 aux reply, 5 mouse
    logic [7:0] m_mode, m_stat, m_port;
    logic       m_a20;
    int         m_pend;

    kbc_cmd_proc u_kbc_cmd_proc (.*);

    always #10 clk = ~clk;

    initial begin
        #4000000;
        failures++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic logic [63:0] pack_out(logic [7:0] st, logic [7:0] md, logic [7:0] pt, logic a20,
                                             logic sr, logic rv, logic ra, logic [7:0] rd,
                                             logic kv, logic [7:0] kd, logic av, logic [7:0] ad,
                                             logic bd, logic xl);
        return {st, md, pt, a20, sr, rv, ra & rv, (rv ? rd : 8'h00), kv, (kv ? kd : 8'h00),
                av, (av ? ad : 8'h00), bd, xl};
    endfunction

    function automatic logic [63:0] dut_out();
        return pack_out(status_byte, mode_byte, port_byte, a20_gate, sys_rst_req, rsp_valid, rsp_aux,
                        rsp_data, kbd_fwd_valid, kbd_fwd_data, aux_fwd_valid, aux_fwd_data,
                        bad_cmd, xlate_en);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 8'h03; m_stat = 8'h18; m_port = 8'hCF; m_a20 = 1'b1; m_pend = 0;
    endtask

    // one host write, then check every output one cycle later
    task automatic apply(logic sel, logic [7:0] d);
        logic sr = 0, rv = 0, ra = 0, kv = 0, av = 0, bd = 0;
        logic [7:0] rd = 0, kd = 0, ad = 0;
        string tag = "R8";
        if (sel) begin
            m_pend = 0;
            casez (d)
                8'h20: begin rv = 1; rd = m_mode; tag = "R3"; end
                8'hD0: begin rv = 1; rd = m_port; tag = "R3"; end
                8'hA9, 8'hAB: begin rv = 1; rd = 8'h00; tag = "R3"; end
                8'hC0: begin rv = 1; rd = 8'h80; tag = "R3"; end
                8'hAA: begin rv = 1; rd = 8'h55; m_stat[2] = 1; tag = "R2"; end
                8'h60: begin m_pend = 1; tag = "R5"; end
                8'hD1: begin m_pend = 2; tag = "R6"; end
                8'hD2: begin m_pend = 3; tag = "R7"; end
                8'hD3: begin m_pend = 4; tag = "R7"; end
                8'hD4: begin m_pend = 5; tag = "R7"; end
                8'hA7: begin m_mode[5] = 1; tag = "R4"; end
                8'hA8: begin m_mode[5] = 0; tag = "R4"; end
                8'hAD: begin m_mode[4] = 1; tag = "R4"; end
                8'hAE: begin m_mode[4] = 0; tag = "R4"; end
                8'hDF: begin m_port[1] = 1; m_a20 = 1; tag = "R9"; end
                8'hDD: begin m_port[1] = 0; m_a20 = 0; tag = "R9"; end
                8'hF?: begin sr = ~d[0]; tag = "R10"; end
                default: begin bd = 1; tag = "R11"; end
            endcase
        end else begin
            case (m_pend)
                1: begin m_mode = d; tag = "R5"; end
                2: begin m_port = d; m_a20 = d[1]; sr = ~d[0]; tag = "R6"; end
                3: begin rv = 1; rd = d; tag = "R7"; end
                4: begin rv = 1; ra = 1; rd = d; tag = "R7"; end
                5: begin av = 1; ad = d; tag = "R7"; end
                default: begin kv = 1; kd = d; tag = "R8"; end
            endcase
            m_pend = 0;
        end
        m_stat[3] = sel;
        host_wr = 1'b1; host_cmd_sel = sel; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
        check(tag, dut_out(), pack_out(m_stat, m_mode, m_port, m_a20, sr, rv, ra, rd, kv, kd, av, ad,
                                       bd, m_mode[6]));
    endtask

    function automatic logic [7:0] pick_cmd(int i);
        case (i)
            0: return 8'h20;  1: return 8'hD0;  2: return 8'hA9;  3: return 8'hAB;
            4: return 8'hC0;  5: return 8'hAA;  6: return 8'h60;  7: return 8'hD1;
            8: return 8'hD2;  9: return 8'hD3;  10: return 8'hD4; 11: return 8'hA7;
            12: return 8'hA8; 13: return 8'hAD; 14: return 8'hAE; 15: return 8'hDF;
            16: return 8'hDD; 17: return 8'hFE; 18: return 8'hFF;
            default: return 8'(($urandom % 256));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        check("R1", dut_out(), pack_out(8'h18, 8'h03, 8'hCF, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
        // R3 replies
        apply(1, 8'h20); apply(1, 8'hD0); apply(1, 8'hC0); apply(1, 8'hAB); apply(1, 8'hA9);
        // R2 self test then data write clears bit 3
        apply(1, 8'hAA); apply(0, 8'h11);
        // R4 mode bits
        apply(1, 8'hAD); apply(1, 8'hA7); apply(1, 8'hAE); apply(1, 8'hA8);
        // R5 mode write with translation bit
        apply(1, 8'h60); apply(0, 8'h43); apply(1, 8'h20);
        // R6 output port write with bit 0 clear, then set
        apply(1, 8'hD1); apply(0, 8'hCC); apply(1, 8'hD1); apply(0, 8'hCF);
        // R7 injections and mouse forward
        apply(1, 8'hD2); apply(0, 8'h9A); apply(1, 8'hD3); apply(0, 8'h5B);
        apply(1, 8'hD4); apply(0, 8'hE6);
        // R8 operand consumed exactly once
        apply(1, 8'h60); apply(0, 8'h01); apply(0, 8'h77);
        // R9 A20 commands
        apply(1, 8'hDD); apply(1, 8'hD0); apply(1, 8'hDF);
        // R10 pulse range
        apply(1, 8'hF0); apply(1, 8'hF1); apply(1, 8'hFC); apply(1, 8'hFF); apply(1, 8'hFE);
        // R11 unknown commands
        apply(1, 8'h00); apply(1, 8'hA1); apply(1, 8'hED);
        // R12 armed operand dropped by later command
        apply(1, 8'hD1); apply(1, 8'hA9); apply(0, 8'h00);
        apply(1, 8'h60); apply(1, 8'hD4); apply(0, 8'h3C);
        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 2 == 0) apply(1, pick_cmd(int'($urandom % 24)));
            else apply(0, 8'(($urandom % 256)));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule